// File: doc/BRIEF.md
# Dual-Edge Framed Serial Transmitter

This block turns short bursts of 16-bit words into framed serial traffic on a source-synchronous link. The link has one forwarded clock and either one or two data lanes. The block runs from an internal clock at twice the link rate. On every internal cycle of a frame, it toggles the forwarded clock and presents new data, so each lane carries one bit per link-clock edge. A configuration input selects one-lane or two-lane operation for each frame.

On the parallel side, a valid/ready handshake delivers a frame type, a word count and the payload words. The block stores the whole burst first. It then closes its input and sends a start marker, the type, the payload, a CRC-8 and an end marker. The transmitter has no dependence on any receiver and takes no master or slave role. When no frame is in flight, the forwarded clock rests low and both lanes rest high.

Top module: `ddr_frame_tx`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, s_ready is 1, link_clk is 0, and link_d0 and link_d1 are 1. A reset during a frame abandons that frame.
- R2: While no frame is being sent, link_clk stays 0 and both lanes stay 1.
- R3: s_len holds the word count minus one, so 0 means 1 word and 15 means 16 words. Type and length are taken only from the first accepted beat of a burst, and the type and length on later beats are ignored. s_ready drops at the edge that accepts the final word. It returns to 1 at the edge that drives the last frame bit. s_valid while s_ready is 0 has no effect.
- R4: During a frame, link_clk changes on every internal clock edge. Its first change is 0 to 1, together with the first bit. The last bit goes out with a 1 to 0 change, so link_clk is low at the end of a frame.
- R5: The bit order within a frame is as follows. First the start marker 4'b0110. Then the 4-bit type, MSB first. Then the payload words in the order they were accepted, each MSB first. Then the CRC. Last, the end marker 4'b1001.
- R6: The CRC is CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final XOR. It covers the 4 type bits and then all payload bits, in transmission order.
- R7: In one-lane mode, link_d0 carries one frame bit per internal cycle and link_d1 stays 1. A frame of n words takes 20+16n cycles.
- R8: In two-lane mode, each cycle carries two adjacent bits of a field. link_d1 takes the higher, odd-indexed bit and link_d0 the next lower, even-indexed bit, starting at the field MSB. The fields are the header byte {start, type}, each payload word, the CRC byte and the end nibble. A frame of n words takes 10+8n cycles.
- R9: The first frame bit appears one internal cycle after the edge that accepts the last word. On the cycle between those two edges, the lanes and link_clk still show idle levels.
- R10: cfg_two_lane is sampled at the edge that accepts the final word. Changing it during the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the link clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_two_lane | input | 1 | 1 selects two-lane mode for the next frame |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block accepts a beat |
| s_type | input | 4 | Frame type, taken on the first beat |
| s_len | input | 4 | Word count minus one, taken on the first beat |
| s_data | input | 16 | Payload word |
| link_clk | output | 1 | Forwarded link clock |
| link_d0 | output | 1 | Mandatory data lane |
| link_d1 | output | 1 | Optional second data lane |

## Verification
A wrong section sequencer or bit counter shows up as a wrong frame length. s_ready then rises early or late, and the table's cycle count exposes the error on the frame's final cycle. A shifter or lane-split fault corrupts the lane values at the first affected bit, at most one internal cycle after it leaves the shift register. A CRC accumulation fault stays hidden until the footer, where all eight checksum bits are compared. A clock-toggle fault is seen on the very next edge, because the bench predicts link_clk for every cycle of each frame.

// File: rtl/ddr_frame_pkg.sv
package ddr_frame_pkg;
  typedef enum logic [1:0] {SEC_HDR, SEC_PAY, SEC_CRC, SEC_END} sec_e;
  localparam int MARK_W = 4;
  localparam logic [MARK_W-1:0] START_PAT = 4'b0110;
  localparam logic [MARK_W-1:0] END_PAT   = 4'b1001;
endpackage

// File: rtl/ddr_frame_buf.sv
module ddr_frame_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ddr_frame_crc.sv
module ddr_frame_crc #(
  parameter int TYPE_W = 4,
  parameter int WORD_W = 16,
  parameter int CRC_W  = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              first,
  input  logic [TYPE_W-1:0] type_in,
  input  logic [WORD_W-1:0] word_in,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] crc_nxt;

  always_comb begin
    logic [CRC_W-1:0] c;
    c = crc_q;
    if (first) begin
      c = '0;
      for (int i = TYPE_W - 1; i >= 0; i--)
        c = (c << 1) ^ ((c[CRC_W-1] ^ type_in[i]) ? CRC_POLY : '0);
    end
    for (int i = WORD_W - 1; i >= 0; i--)
      c = (c << 1) ^ ((c[CRC_W-1] ^ word_in[i]) ? CRC_POLY : '0);
    crc_nxt = c;
  end

  always_ff @(posedge clk) begin
    if (rst)      crc_q <= '0;
    else if (upd) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/ddr_frame_ser.sv
module ddr_frame_ser
  import ddr_frame_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 4,
  parameter int TYPE_W = 4,
  parameter int CRC_W  = 8,
  localparam int HDR_W = MARK_W + TYPE_W,
  localparam int BL_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              two_lane,
  input  logic [TYPE_W-1:0] hdr_type,
  input  logic [LEN_W-1:0]  len,
  input  logic [CRC_W-1:0]  crc,
  output logic [LEN_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              active,
  output logic              link_clk,
  output logic              link_d0,
  output logic              link_d1
);
  sec_e              sec;
  logic [BL_W-1:0]   bl;
  logic [LEN_W-1:0]  widx;
  logic [WORD_W-1:0] sr;
  logic [BL_W-1:0]   step;

  assign step    = two_lane ? BL_W'(2) : BL_W'(1);
  assign rd_addr = (sec == SEC_PAY) ? LEN_W'(widx + 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      sec      <= SEC_HDR;
      bl       <= '0;
      widx     <= '0;
      sr       <= '0;
      link_clk <= 1'b0;
      link_d0  <= 1'b1;
      link_d1  <= 1'b1;
    end else if (start) begin
      active   <= 1'b1;
      sec      <= SEC_HDR;
      sr       <= WORD_W'({START_PAT, hdr_type}) << (WORD_W - HDR_W);
      bl       <= BL_W'(HDR_W);
      widx     <= '0;
      link_clk <= 1'b0;
      link_d0  <= 1'b1;
      link_d1  <= 1'b1;
    end else if (active) begin
      link_clk <= ~link_clk;
      link_d0  <= two_lane ? sr[WORD_W-2] : sr[WORD_W-1];
      link_d1  <= two_lane ? sr[WORD_W-1] : 1'b1;
      if (bl == step) begin
        unique case (sec)
          SEC_HDR: begin
            sec <= SEC_PAY;
            sr  <= rd_data;
            bl  <= BL_W'(WORD_W);
          end
          SEC_PAY: begin
            if (widx == len) begin
              sec <= SEC_CRC;
              sr  <= WORD_W'(crc) << (WORD_W - CRC_W);
              bl  <= BL_W'(CRC_W);
            end else begin
              widx <= widx + 1'b1;
              sr   <= rd_data;
              bl   <= BL_W'(WORD_W);
            end
          end
          SEC_CRC: begin
            sec <= SEC_END;
            sr  <= WORD_W'(END_PAT) << (WORD_W - MARK_W);
            bl  <= BL_W'(MARK_W);
          end
          default: begin
            active <= 1'b0;
            sec    <= SEC_HDR;
          end
        endcase
      end else begin
        sr <= two_lane ? (sr << 2) : (sr << 1);
        bl <= bl - step;
      end
    end else begin
      link_clk <= 1'b0;
      link_d0  <= 1'b1;
      link_d1  <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr_frame_tx.sv
module ddr_frame_tx #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 16,
  parameter int TYPE_W    = 4,
  parameter int CRC_W     = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  localparam int LEN_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_two_lane,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [TYPE_W-1:0] s_type,
  input  logic [LEN_W-1:0]  s_len,
  input  logic [WORD_W-1:0] s_data,
  output logic              link_clk,
  output logic              link_d0,
  output logic              link_d1
);
  logic              busy;
  logic [LEN_W-1:0]  wr_cnt;
  logic [LEN_W-1:0]  len_q;
  logic [TYPE_W-1:0] type_q;
  logic              two_q;
  logic              beat, first, last;
  logic [LEN_W-1:0]  cur_len;
  logic [TYPE_W-1:0] hdr_type;
  logic [CRC_W-1:0]  crc_q;
  logic [LEN_W-1:0]  rd_addr;
  logic [WORD_W-1:0] rd_data;

  assign s_ready  = ~busy;
  assign beat     = s_valid & s_ready;
  assign first    = (wr_cnt == '0);
  assign cur_len  = first ? s_len : len_q;
  assign last     = beat & (wr_cnt == cur_len);
  assign hdr_type = first ? s_type : type_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      len_q  <= '0;
      type_q <= '0;
      two_q  <= 1'b0;
    end else if (beat) begin
      if (first) begin
        len_q  <= s_len;
        type_q <= s_type;
      end
      if (last) begin
        wr_cnt <= '0;
        two_q  <= cfg_two_lane;
      end else begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end

  ddr_frame_buf #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) u_buf (
    .clk(clk), .we(beat), .waddr(wr_cnt), .wdata(s_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  ddr_frame_crc #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .upd(beat), .first(first),
    .type_in(s_type), .word_in(s_data), .crc_q(crc_q)
  );

  ddr_frame_ser #(.WORD_W(WORD_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W), .CRC_W(CRC_W)) u_ser (
    .clk(clk), .rst(rst), .start(last), .two_lane(two_q),
    .hdr_type(hdr_type), .len(len_q), .crc(crc_q),
    .rd_addr(rd_addr), .rd_data(rd_data), .active(busy),
    .link_clk(link_clk), .link_d0(link_d0), .link_d1(link_d1)
  );
endmodule

// File: rtl/ddr_frame_tx_chk.sv
module ddr_frame_tx_chk #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 16,
  parameter int TYPE_W    = 4,
  parameter int CRC_W     = 8,
  localparam int LEN_W    = $clog2(MAX_WORDS),
  localparam int MAXBITS  = 4 + TYPE_W + MAX_WORDS * WORD_W + CRC_W + 4,
  localparam int CNT_W    = $clog2(MAXBITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             two_lane,
  input logic [LEN_W-1:0] len,
  input logic             s_ready,
  input logic             link_clk,
  input logic             link_d0,
  input logic             link_d1
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] exp_cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (busy) cnt <= cnt + 1'b1;
    else           cnt <= '0;
  end

  always_comb begin
    int bits;
    bits    = 4 + TYPE_W + (int'(len) + 1) * WORD_W + CRC_W + 4;
    exp_cnt = CNT_W'(two_lane ? bits / 2 : bits);
  end

  a_r2_idle_levels: assert property (@(posedge clk) disable iff (rst)
    (s_ready && $past(s_ready)) |-> (!link_clk && link_d0 && link_d1));

  a_r4_clk_toggles: assert property (@(posedge clk) disable iff (rst)
    busy |=> (link_clk != $past(link_clk)));

  a_r4_clk_ends_low: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !link_clk);

  a_r7_d1_high: assert property (@(posedge clk) disable iff (rst)
    (busy && !two_lane) |=> link_d1);

  // R7 and R8: frame duration in internal cycles
  a_r7_frame_len: assert property (@(posedge clk) disable iff (rst)
    (!busy && cnt != '0) |-> (cnt == exp_cnt));
endmodule

bind ddr_frame_tx ddr_frame_tx_chk #(
  .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .TYPE_W(TYPE_W), .CRC_W(CRC_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .two_lane(two_q), .len(len_q),
  .s_ready(s_ready), .link_clk(link_clk), .link_d0(link_d0), .link_d1(link_d1)
);

// File: tb/ddr_frame_tx_bench.sv
module ddr_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_two_lane = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [3:0]  s_type = '0;
  logic [3:0]  s_len = '0;
  logic [15:0] s_data = '0;
  logic        link_clk, link_d0, link_d1;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ddr_frame_tx u_ddr_frame_tx (
    .clk(clk), .rst(rst), .cfg_two_lane(cfg_two_lane),
    .s_valid(s_valid), .s_ready(s_ready), .s_type(s_type),
    .s_len(s_len), .s_data(s_data),
    .link_clk(link_clk), .link_d0(link_d0), .link_d1(link_d1)
  );

  // {two_lane, type, len-1, seed, expected frame cycles}
  localparam logic [33:0] VEC [0:6] = '{
    {1'b0, 4'h3, 4'd0,  16'hA5C3, 9'd36},
    {1'b1, 4'hC, 4'd0,  16'h0F0F, 9'd18},
    {1'b0, 4'h5, 4'd3,  16'h1234, 9'd84},
    {1'b1, 4'h9, 4'd7,  16'hBEEF, 9'd74},
    {1'b0, 4'hF, 4'd15, 16'h0000, 9'd276},
    {1'b1, 4'h0, 4'd15, 16'hFFFF, 9'd138},
    {1'b1, 4'h6, 4'd2,  16'h7E81, 9'd34}
  };

  bit exp_bits [0:287];
  int nbits;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int i);
    return seed + 16'(i * 15193);
  endfunction

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [15:0] d, input int n);
    logic fb;
    for (int b = n - 1; b >= 0; b--) begin
      fb = c[7] ^ d[b];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic push(input logic [15:0] v, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      exp_bits[nbits] = v[b];
      nbits++;
    end
  endtask

  task automatic check_idle(input string req);
    check(s_ready == 1'b1, req, "s_ready", int'(s_ready), 1);
    check({link_clk, link_d0, link_d1} == 3'b011, req, "clk/d0/d1",
          int'({link_clk, link_d0, link_d1}), 3);
  endtask

  task automatic run_frame(input logic [33:0] v, input bit disturb);
    logic       two;
    logic [3:0] typ, lenm1;
    logic [15:0] seed;
    int         expc, derr, cerr, rerr, first_k, act_v, exp_v;
    logic [7:0] crc;
    logic       e0, e1;
    two = v[33]; typ = v[32:29]; lenm1 = v[28:25]; seed = v[24:9]; expc = int'(v[8:0]);
    nbits = 0;
    push({8'h00, 4'b0110, typ}, 8);
    crc = crc_upd(8'h00, {12'h000, typ}, 4);
    for (int i = 0; i <= int'(lenm1); i++) begin
      push(word_of(seed, i), 16);
      crc = crc_upd(crc, word_of(seed, i), 16);
    end
    push({8'h00, crc}, 8);
    push(16'h0009, 4);
    // load burst; later beats carry wrong type/length that must be ignored (R3)
    for (int i = 0; i <= int'(lenm1); i++) begin
      @(negedge clk);
      check(s_ready == 1'b1, "R3", "s_ready during load", int'(s_ready), 1);
      cfg_two_lane = two;
      s_valid = 1'b1;
      s_type  = (i == 0) ? typ : ~typ;
      s_len   = (i == 0) ? lenm1 : ~lenm1;
      s_data  = word_of(seed, i);
    end
    @(negedge clk);
    s_valid = disturb;
    s_data  = 16'hDEAD;
    s_type  = 4'hA;
    s_len   = 4'h1;
    cfg_two_lane = disturb ? ~two : two;
    check(s_ready == 1'b0, "R3", "s_ready after final word", int'(s_ready), 0);
    check({link_clk, link_d0, link_d1} == 3'b011, "R9", "idle before first bit",
          int'({link_clk, link_d0, link_d1}), 3);
    derr = 0; cerr = 0; rerr = 0; first_k = -1; act_v = 0; exp_v = 0;
    for (int k = 0; k < expc; k++) begin
      @(negedge clk);
      if (two) begin e1 = exp_bits[2*k]; e0 = exp_bits[2*k+1]; end
      else     begin e1 = 1'b1;          e0 = exp_bits[k];     end
      if ({link_d1, link_d0} != {e1, e0}) begin
        derr++;
        if (first_k < 0) begin
          first_k = k; act_v = int'({link_d1, link_d0}); exp_v = int'({e1, e0});
        end
      end
      if (link_clk != ((k % 2) == 0)) cerr++;
      if (s_ready != (k == expc - 1)) rerr++;
      if (k == expc - 2) s_valid = 1'b0;
    end
    if (derr != 0) $display("  first lane mismatch at cycle %0d", first_k);
    check(derr == 0, two ? "R5 R6 R8" : "R5 R6 R7", "lane bits {d1,d0}", act_v, exp_v);
    check(cerr == 0, "R4", "link_clk toggle errors", cerr, 0);
    check(rerr == 0, two ? "R3 R8" : "R3 R7", "s_ready window errors", rerr, 0);
    if (disturb)
      check(derr == 0 && rerr == 0, "R10", "mode flip and valid mid-frame", derr + rerr, 0);
    @(negedge clk);
    cfg_two_lane = two;
    check_idle("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");
    repeat (2) @(negedge clk);
    check_idle("R2");

    for (int e = 0; e < 7; e++) run_frame(VEC[e], e == 6);

    // reset in the middle of a frame
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_type = 4'h5; s_len = 4'd3; s_data = word_of(16'h4444, i);
    end
    @(negedge clk);
    s_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(s_ready == 1'b0, "R3", "busy mid-frame", int'(s_ready), 0);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");
    run_frame(VEC[1], 1'b0);
    run_frame(VEC[0], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule